// File: doc/BRIEF.md
# Programmable Threshold Gate Cell

This cell can be set up to behave as any threshold gate with up to four inputs and hysteresis. Such gates are the basic elements of dual-rail, self-timed logic. The cell has two phases. While the program select is high, it loads three things:

- a 14-bit truth-table word,
- a reset value,
- an output-inversion flag.

When the program select goes low, the cell operates. The four gate inputs form an address into a 16-entry lookup table. The two end entries are fixed: entry 0 is always 0 and entry 15 is always 1. The other 14 entries come from the loaded word.

A table hit sets an internal state bit. The state clears only when all four inputs are 0, and it holds its value in every other case. A gate reset input forces the state to the loaded reset value. The output is the state, or its complement when the inversion flag is loaded as 1.

The cell is modelled as clocked logic and samples its inputs on every rising clock edge. A gate with fewer than four inputs is built by tying the unused inputs to 0 and programming only the entries that remain reachable. For example, a 2-of-3 gate sets entries 6, 10, 12 and 14 and ties `d` low.

Top module: `thresh_le`

## Requirements
- R1: While `prog` is 1, each rising edge loads `cfg_tt`, `rv` and `inv` into storage. Table entry k (k = 1 to 14) takes the value of `cfg_tt[k]`.
- R2: Table entry 0 reads as 0 and entry 15 reads as 1 for every loaded word. With a word of all zeros the cell acts as a four-input C-element.
- R3: The table address is {a,b,c,d}, with `a` as the most significant bit. For example, a=1 with b=c=d=0 selects entry 8.
- R4: In operation (prog=0, grst=0), if the addressed entry is 1 at a rising edge, the state becomes 1 after that edge.
- R5: In operation, if a=b=c=d=0 at an edge, the state becomes 0. If the addressed entry is 0 and at least one input is 1, the state keeps its value.
- R6: In operation, grst=1 forces the state to the loaded reset value, with priority over set and clear. After grst is released, that value is held until a set or clear condition occurs.
- R7: `z` equals the state when the loaded inversion flag is 0 and its complement when the flag is 1. The flag also applies to the reset value.
- R8: While `prog` is 1, the state is cleared to 0 and `a`..`d` and `grst` have no effect. While `prog` is 0, changes on `cfg_tt`, `rv` and `inv` have no effect.
- R9: A low level on `rst_n` clears the stored word, both flags and the state at once, so `z` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| prog | input | 1 | 1 = programming phase, 0 = operating phase |
| cfg_tt | input | 14 | Truth-table entries 1 to 14, indexed [14:1] |
| rv | input | 1 | Reset value to load |
| inv | input | 1 | Output inversion flag to load |
| a | input | 1 | Gate input, address MSB |
| b | input | 1 | Gate input |
| c | input | 1 | Gate input |
| d | input | 1 | Gate input, address LSB |
| grst | input | 1 | Gate reset, active high, acts in the operating phase |
| z | output | 1 | Gate output |

## Verification
The assertions check the following rules on every cycle:

- the all-ones input always sets the state,
- the all-zeros input always clears it,
- gate reset loads the stored value,
- programming clears the state,
- configuration storage stays frozen outside the programming phase,
- the state holds on an input pattern that neither sets nor clears.

Some behaviours only the bench's scenarios can show. These are the mapping of each `cfg_tt` bit to its input pattern, the address bit order, the inversion seen at `z`, and whole rising and falling sequences that match threshold-gate equations. The equations covered are the four-input C-element, AB + ACD, 2-of-3, and a single-entry gate.

// File: rtl/thresh_le.sv
module thresh_le #(
  parameter int NIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic [14:1]       cfg_tt,
  input  logic              rv,
  input  logic              inv,
  input  logic              a,
  input  logic              b,
  input  logic              c,
  input  logic              d,
  input  logic              grst,
  output logic              z
);
  localparam int DEPTH = 1 << NIN;

  logic [DEPTH-2:1] cfg_q;
  logic             rv_q, inv_q, st_q;
  logic [NIN-1:0]   sel;
  logic [DEPTH-1:0] lut;

  assign sel = {a, b, c, d};
  assign lut = {1'b1, cfg_q, 1'b0};
  assign z   = st_q ^ inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rv_q  <= 1'b0;
      inv_q <= 1'b0;
    end else if (prog) begin
      cfg_q <= cfg_tt;
      rv_q  <= rv;
      inv_q <= inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             st_q <= 1'b0;
    else if (prog)          st_q <= 1'b0;
    else if (grst)          st_q <= rv_q;
    else if (lut[sel])      st_q <= 1'b1;
    else if (sel == '0)     st_q <= 1'b0;
  end

  AST_ALL_ONES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog && !grst && a && b && c && d) |=> st_q);                  // R2
  AST_ALL_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog && !grst && !a && !b && !c && !d) |=> !st_q);             // R5
  AST_NO_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog && !grst && !lut[sel] && sel != '0) |=> $stable(st_q));   // R5
  AST_RESET_LOADS_RV: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog && grst) |=> (st_q == rv_q));                             // R6
  AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> !st_q);                                                 // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |=> ($stable(cfg_q) && $stable(rv_q) && $stable(inv_q)));  // R8
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (cfg_q == $past(cfg_tt) && rv_q == $past(rv) && inv_q == $past(inv))); // R1
endmodule

// File: tb/thresh_le_tb.sv
module thresh_le_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog = 1'b0;
  logic [14:1] cfg_tt = '0;
  logic rv = 1'b0, inv = 1'b0;
  logic a = 1'b0, b = 1'b0, c = 1'b0, d = 1'b0, grst = 1'b0;
  logic z;

  int n_chk = 0, n_bad = 0;
  int gate_id = 0;
  logic m_st = 1'b0, m_rv = 1'b0, m_inv = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thresh_le dut_i (.clk(clk), .rst_n(rst_n), .prog(prog), .cfg_tt(cfg_tt),
    .rv(rv), .inv(inv), .a(a), .b(b), .c(c), .d(d), .grst(grst), .z(z));

  function automatic logic gate_f(input int id, input logic [3:0] v);
    logic fa, fb, fc, fd;
    {fa, fb, fc, fd} = v;
    case (id)
      0: return fa & fb & fc & fd;
      1: return (fa & fb) | (fa & fc & fd);
      2: return (fa & fb) | (fa & fc) | (fb & fc);
      default: return (v == 4'b1000) || (v == 4'b1111);
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (z !== exp) begin
      n_bad++;
      $display("FAIL %s: z=%b expected %b (abcd=%b%b%b%b grst=%b)", req, z, exp, a, b, c, d, grst);
    end
  endtask

  task automatic load(input logic [14:1] w, input logic r, input logic iv, input int id);
    @(negedge clk);
    prog = 1'b1; cfg_tt = w; rv = r; inv = iv;
    @(posedge clk);
    @(negedge clk);
    prog = 1'b0; cfg_tt = ~w; rv = ~r; inv = ~iv;
    gate_id = id; m_st = 1'b0; m_rv = r; m_inv = iv;
    check("R1", m_inv);
  endtask

  task automatic step(input logic [3:0] v, input logic gr, input string req);
    @(negedge clk);
    {a, b, c, d} = v; grst = gr;
    @(posedge clk);
    if (gr) m_st = m_rv;
    else if (gate_f(gate_id, v)) m_st = 1'b1;
    else if (v == 4'b0000) m_st = 1'b0;
    #1 check(req, m_st ^ m_inv);
  endtask

  task automatic t_reset_state;
    #1 check("R9", 1'b0);
  endtask

  task automatic t_celement;
    load(14'b0, 1'b1, 1'b0, 0);
    step(4'b1000, 0, "R2"); step(4'b1100, 0, "R2"); step(4'b1110, 0, "R2");
    step(4'b1111, 0, "R2");
    step(4'b0111, 0, "R5"); step(4'b0011, 0, "R5"); step(4'b0001, 0, "R5");
    step(4'b0000, 0, "R5");
    step(4'b0010, 1, "R6"); step(4'b0010, 0, "R6"); step(4'b0000, 0, "R6");
  endtask

  task automatic t_ab_acd;
    load(14'b11110000000000, 1'b0, 1'b0, 1);
    step(4'b1000, 0, "R4"); step(4'b1010, 0, "R4"); step(4'b1011, 0, "R4");
    step(4'b0011, 0, "R5"); step(4'b0001, 0, "R5"); step(4'b0000, 0, "R5");
    step(4'b1000, 0, "R4"); step(4'b1100, 0, "R4");
    step(4'b1100, 1, "R6"); step(4'b0000, 0, "R5");
  endtask

  task automatic t_th23_inv;
    load(14'b10101000100000, 1'b0, 1'b1, 2);
    step(4'b0100, 0, "R7"); step(4'b0110, 0, "R7"); step(4'b1110, 0, "R7");
    step(4'b1010, 0, "R7"); step(4'b0010, 0, "R7"); step(4'b0000, 0, "R7");
    step(4'b1010, 0, "R7"); step(4'b1010, 1, "R7"); step(4'b0000, 0, "R7");
  endtask

  task automatic t_addr_order;
    load(14'b00000010000000, 1'b1, 1'b0, 3);
    step(4'b0001, 0, "R3"); step(4'b0000, 0, "R3");
    step(4'b1000, 0, "R3"); step(4'b0000, 0, "R3");
  endtask

  task automatic t_prog_ignore;
    load(14'b0, 1'b0, 1'b0, 0);
    step(4'b1111, 0, "R8");
    @(negedge clk);
    prog = 1'b1; cfg_tt = 14'b0; rv = 1'b0; inv = 1'b0; a = 1; b = 1; c = 1; d = 1; grst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 check("R8", 1'b0);
    @(negedge clk);
    prog = 1'b0; grst = 1'b0; {a, b, c, d} = 4'b0000;
    cfg_tt = 14'h3fff; rv = 1'b1; inv = 1'b1; m_st = 1'b0;
    step(4'b1000, 0, "R8"); step(4'b1110, 0, "R8");
    step(4'b0000, 1, "R8");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual not done expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #12;
    t_reset_state();
    @(negedge clk); rst_n = 1'b1;
    t_celement();
    t_ab_acd();
    t_th23_inv();
    t_addr_order();
    t_prog_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule